// File: doc/BRIEF.md
# SPI Control-Register Access Port

This block is the serial front end of a device's small control-register bank. A host talks to it over a mode-0 SPI link (data sampled on the rising clock edge and changed on the falling edge, most significant bit first). After the select line goes low, the first byte is an opcode. Two opcodes belong to this block: 12h writes registers and 13h reads them. Any other opcode is handed to a separate command handler as a one-cycle strobe, and the rest of that transaction is ignored.

For both register opcodes, the next byte is a register address. Data bytes then follow as a stream, and the address steps forward after each byte. The bank holds 30 registers, so after address 1Dh the next address is 00h. Writes are gated by a write-enable latch. The command handler sets or clears the latch through two pulse inputs. This block clears the latch when the host deselects after a write command.

The register file is outside the block. The block drives its one-cycle write strobe and its read request. Read data is expected one clock after the request. All SPI pins are synchronised into the system clock domain, so the serial clock must be several times slower than the system clock.

Top module: `spi_creg_port`

## Requirements
- R1: After reset, spi_miso_oe, wel, rf_we, rf_re and op_valid are all 0.
- R2: With opcode 12h, the byte after the opcode is the start address. Each later complete byte produces one rf_we pulse carrying that byte and the current address, and the address then steps by one.
- R3: While wel is 0, no rf_we pulse is issued for any data byte, and the register keeps its value.
- R4: The register address steps from 1Dh to 00h, in both write and read bursts.
- R5: A start address byte of 1Eh or above is replaced by 00h.
- R6: Bits of an incomplete byte at the moment select rises are discarded, and no register is written for them.
- R7: A rising select after an opcode 12h has been fully received clears wel. A read transaction leaves wel unchanged.
- R8: A pulse on wel_set makes wel 1 and a pulse on wel_clr makes it 0. When both pulse together, wel_clr wins.
- R9: With opcode 13h, register data goes out on spi_miso MSB first, starting with the first clock of the byte after the address. spi_miso_oe is 1 only during that data phase, and 0 while the opcode and address bytes are shifted and after deselect.
- R10: Any opcode other than 12h or 13h gives one op_valid pulse with that code on op_code. The rest of that transaction produces no register access, no wel change and no output enable.
- R11: A rising select abandons any partial command. The next selection starts again with an opcode byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for spi_miso (pad is high impedance when 0) |
| wel_set | input | 1 | Pulse from command handler: set write-enable latch |
| wel_clr | input | 1 | Pulse from command handler: clear write-enable latch |
| wel | output | 1 | Write-enable latch state |
| rf_we | output | 1 | Register file write strobe |
| rf_waddr | output | 5 | Register file write address |
| rf_wdata | output | 8 | Register file write data |
| rf_re | output | 1 | Register file read request |
| rf_raddr | output | 5 | Register file read address |
| rf_rdata | input | 8 | Register file read data, valid one clock after rf_re |
| op_valid | output | 1 | Strobe: foreign opcode received |
| op_code | output | 8 | The foreign opcode |

## Verification
The hardest cases sit at the edges of a byte and a transaction. One is a select that rises partway through a byte, either in the data phase or in the opcode itself. Another is an address that crosses 1Dh while the read prefetch is already running ahead by one register. The bench uses a bit-level transaction task that can append a chosen number of trailing clocks. It starts bursts at 1Ch, 1Dh and out-of-range addresses, so the wrap and the truncated-byte paths are reached from the pins alone. Latch gating is checked by writing with the latch both set and cleared. It is also checked by sending a foreign opcode followed by bytes that look like a write command.

// File: rtl/creg_pkg.sv
package creg_pkg;
  typedef enum logic [2:0] {
    ST_OPC,
    ST_WADDR,
    ST_RADDR,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } creg_state_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_act,
  output logic cs_rise,
  output logic mosi_s
);
  logic [SYNC:0]   sck_p;
  logic [SYNC:0]   cs_p;
  logic [SYNC-1:0] mosi_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_p  <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
    end else begin
      sck_p  <= {sck_p[SYNC-1:0], sck};
      cs_p   <= {cs_p[SYNC-1:0], cs_n};
      mosi_p <= {mosi_p[SYNC-2:0], mosi};
    end
  end

  assign sck_rise = sck_p[SYNC-1] & ~sck_p[SYNC];
  assign sck_fall = ~sck_p[SYNC-1] & sck_p[SYNC];
  assign cs_act   = ~cs_p[SYNC-1];
  assign cs_rise  = cs_p[SYNC-1] & ~cs_p[SYNC];
  assign mosi_s   = mosi_p[SYNC-1];
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_act,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          mosi_s,
  input  logic          tx_load,
  input  logic [DW-1:0] tx_byte,
  output logic [DW-1:0] rx_byte,
  output logic          rx_done,
  output logic          miso
);
  localparam int BW = $clog2(DW);

  logic [BW-1:0] bit_cnt;
  logic [DW-1:0] rx_sr;
  logic [DW-1:0] tx_sr;

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      bit_cnt <= '0;
    end else if (sck_rise) begin
      bit_cnt <= (bit_cnt == BW'(DW-1)) ? '0 : bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sr <= '0;
    end else if (cs_act && sck_rise) begin
      rx_sr <= {rx_sr[DW-2:0], mosi_s};
    end
  end

  // Shift only inside a byte: the falling edge right after a byte boundary
  // must keep the freshly loaded MSB on the line.
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr <= '0;
    end else if (tx_load) begin
      tx_sr <= tx_byte;
    end else if (cs_act && sck_fall && bit_cnt != '0) begin
      tx_sr <= {tx_sr[DW-2:0], 1'b0};
    end
  end

  assign rx_byte = {rx_sr[DW-2:0], mosi_s};
  assign rx_done = cs_act && sck_rise && (bit_cnt == BW'(DW-1));
  assign miso    = tx_sr[DW-1];

  assert_load_msb_R9: assert property (@(posedge clk) disable iff (rst)
    tx_load |=> (miso == $past(tx_byte[DW-1])));
  assert_byte_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> (rx_done == 1'b0));
endmodule

// File: rtl/creg_seq.sv
module creg_seq
  import creg_pkg::*;
#(
  parameter int NREGS = 30,
  parameter int DW    = 8,
  parameter int AW    = 5,
  parameter int WR_OP = 'h12,
  parameter int RD_OP = 'h13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_act,
  input  logic          cs_rise,
  input  logic          rx_done,
  input  logic [DW-1:0] rx_byte,
  input  logic          wel_set,
  input  logic          wel_clr,
  output logic          wel,
  output logic          rf_we,
  output logic [AW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic          rf_re,
  output logic [AW-1:0] rf_raddr,
  output logic          tx_load,
  output logic          miso_oe,
  output logic          op_valid,
  output logic [DW-1:0] op_code
);
  creg_state_e   state;
  logic [AW-1:0] ptr;
  logic [AW-1:0] start_a;
  logic          wr_seen;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a);
    return (a == AW'(NREGS-1)) ? '0 : a + 1'b1;
  endfunction

  always_comb start_a = (rx_byte < DW'(NREGS)) ? rx_byte[AW-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      wel <= 1'b0;
    end else if (wel_clr || (cs_rise && wr_seen)) begin
      wel <= 1'b0;
    end else if (wel_set) begin
      wel <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_OPC;
      ptr      <= '0;
      wr_seen  <= 1'b0;
      rf_we    <= 1'b0;
      rf_waddr <= '0;
      rf_wdata <= '0;
      rf_re    <= 1'b0;
      rf_raddr <= '0;
      tx_load  <= 1'b0;
      miso_oe  <= 1'b0;
      op_valid <= 1'b0;
      op_code  <= '0;
    end else begin
      rf_we    <= 1'b0;
      rf_re    <= 1'b0;
      op_valid <= 1'b0;
      tx_load  <= rf_re;
      miso_oe  <= cs_act && (state == ST_RDATA);
      if (!cs_act) begin
        state   <= ST_OPC;
        wr_seen <= 1'b0;
      end else if (rx_done) begin
        case (state)
          ST_OPC: begin
            if (rx_byte == DW'(WR_OP)) begin
              state   <= ST_WADDR;
              wr_seen <= 1'b1;
            end else if (rx_byte == DW'(RD_OP)) begin
              state <= ST_RADDR;
            end else begin
              op_valid <= 1'b1;
              op_code  <= rx_byte;
              state    <= ST_SKIP;
            end
          end
          ST_WADDR: begin
            ptr   <= start_a;
            state <= ST_WDATA;
          end
          ST_RADDR: begin
            rf_re    <= 1'b1;
            rf_raddr <= start_a;
            ptr      <= nxt(start_a);
            state    <= ST_RDATA;
          end
          ST_WDATA: begin
            if (wel) begin
              rf_we    <= 1'b1;
              rf_waddr <= ptr;
              rf_wdata <= rx_byte;
            end
            ptr <= nxt(ptr);
          end
          ST_RDATA: begin
            rf_re    <= 1'b1;
            rf_raddr <= ptr;
            ptr      <= nxt(ptr);
          end
          default: ;
        endcase
      end
    end
  end

  assert_we_gated_R3: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> $past(wel));
  assert_addr_range_R4: assert property (@(posedge clk) disable iff (rst)
    (rf_we |-> (rf_waddr < AW'(NREGS))) and (rf_re |-> (rf_raddr < AW'(NREGS))));
  assert_wel_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && wr_seen) |=> !wel);
  assert_oe_selected_R9: assert property (@(posedge clk) disable iff (rst)
    miso_oe |-> $past(cs_act));
  assert_no_we_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (rf_we || op_valid) |-> $past(cs_act));
endmodule

// File: rtl/spi_creg_port.sv
module spi_creg_port #(
  parameter int NREGS = 30,
  parameter int DW    = 8,
  parameter int SYNC  = 2,
  parameter int WR_OP = 'h12,
  parameter int RD_OP = 'h13,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          spi_sck,
  input  logic          spi_cs_n,
  input  logic          spi_mosi,
  output logic          spi_miso,
  output logic          spi_miso_oe,
  input  logic          wel_set,
  input  logic          wel_clr,
  output logic          wel,
  output logic          rf_we,
  output logic [AW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic          rf_re,
  output logic [AW-1:0] rf_raddr,
  input  logic [DW-1:0] rf_rdata,
  output logic          op_valid,
  output logic [DW-1:0] op_code
);
  logic          sck_rise, sck_fall, cs_act, cs_rise, mosi_s;
  logic          rx_done, tx_load;
  logic [DW-1:0] rx_byte;

  spi_pin_sync #(.SYNC(SYNC)) sync_i (
    .clk(clk), .rst(rst), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act),
    .cs_rise(cs_rise), .mosi_s(mosi_s)
  );

  spi_byte_shifter #(.DW(DW)) shf_i (
    .clk(clk), .rst(rst), .cs_act(cs_act), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .mosi_s(mosi_s), .tx_load(tx_load),
    .tx_byte(rf_rdata), .rx_byte(rx_byte), .rx_done(rx_done), .miso(spi_miso)
  );

  creg_seq #(
    .NREGS(NREGS), .DW(DW), .AW(AW), .WR_OP(WR_OP), .RD_OP(RD_OP)
  ) seq_i (
    .clk(clk), .rst(rst), .cs_act(cs_act), .cs_rise(cs_rise),
    .rx_done(rx_done), .rx_byte(rx_byte), .wel_set(wel_set),
    .wel_clr(wel_clr), .wel(wel), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .rf_re(rf_re), .rf_raddr(rf_raddr),
    .tx_load(tx_load), .miso_oe(spi_miso_oe), .op_valid(op_valid),
    .op_code(op_code)
  );
endmodule

// File: tb/spi_creg_port_tb.sv
`timescale 1ns/1ps
module spi_creg_port_tb_top;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe;
  logic wel_set = 1'b0, wel_clr = 1'b0, wel;
  logic rf_we, rf_re, op_valid;
  logic [4:0] rf_waddr, rf_raddr;
  logic [7:0] rf_wdata, rf_rdata, op_code;

  always #5 clk = ~clk;

  spi_creg_port dut_i (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .wel_set(wel_set), .wel_clr(wel_clr), .wel(wel), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .rf_re(rf_re),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .op_valid(op_valid),
    .op_code(op_code)
  );

  // Register file model driven only by the port signals.
  logic [7:0] mem [0:29];
  logic [7:0] exp_m [0:29];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 30; i++) mem[i] <= 8'hA0 + 8'(i);
      rf_rdata <= 8'h00;
    end else begin
      if (rf_re) rf_rdata <= mem[rf_raddr];
      if (rf_we) mem[rf_waddr] <= rf_wdata;
    end
  end

  int we_cnt = 0, op_cnt = 0, strobe_seen = 0;
  logic [7:0] last_op = 8'h00;
  always @(posedge clk) begin
    if (!rst) begin
      if (rf_we) we_cnt++;
      if (op_valid) begin op_cnt++; last_op = op_code; end
    end else if (rf_we || rf_re || op_valid) strobe_seen++;
  end

  int tests = 0, fails = 0;
  logic [7:0] tx_buf [0:7];
  logic [7:0] rx_buf [0:7];
  logic oe_any [0:7];
  logic oe_all [0:7];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_mem(input string req);
    int bad = 0;
    for (int i = 0; i < 30; i++) if (mem[i] !== exp_m[i]) bad++;
    tests++;
    if (bad != 0) begin
      fails++;
      for (int i = 0; i < 30; i++)
        if (mem[i] !== exp_m[i])
          $display("FAIL %s reg %0h actual=%0h expected=%0h", req, i, mem[i], exp_m[i]);
    end
  endtask

  task automatic half_bit();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic spi_run(input int nbytes, input int extra_bits);
    spi_cs_n = 1'b0;
    half_bit();
    for (int i = 0; i < nbytes; i++) begin
      oe_any[i] = 1'b0;
      oe_all[i] = 1'b1;
      for (int k = 7; k >= 0; k--) begin
        spi_mosi = tx_buf[i][k];
        half_bit();
        rx_buf[i][k] = spi_miso;
        oe_any[i] = oe_any[i] | spi_miso_oe;
        oe_all[i] = oe_all[i] & spi_miso_oe;
        spi_sck = 1'b1;
        half_bit();
        spi_sck = 1'b0;
      end
    end
    for (int k = 0; k < extra_bits; k++) begin
      spi_mosi = 1'b1;
      half_bit();
      spi_sck = 1'b1;
      half_bit();
      spi_sck = 1'b0;
    end
    half_bit();
    spi_cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic pulse_set();
    wel_set = 1'b1; @(negedge clk); wel_set = 1'b0; @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 miso_oe", spi_miso_oe, 0);
    chk("R1 wel", wel, 0);
    chk("R1 strobes", {rf_we, rf_re, op_valid}, 0);
    chk("R1 strobes during reset", strobe_seen, 0);
  endtask

  task automatic t_locked_write();
    int w0 = we_cnt;
    tx_buf[0] = 8'h12; tx_buf[1] = 8'h03; tx_buf[2] = 8'hAA;
    spi_run(3, 0);
    chk("R3 no strobe when latch clear", we_cnt - w0, 0);
    chk_mem("R3 register unchanged");
  endtask

  task automatic t_latch_ctrl();
    pulse_set();
    chk("R8 set", wel, 1);
    wel_set = 1'b1; wel_clr = 1'b1; @(negedge clk);
    wel_set = 1'b0; wel_clr = 1'b0; @(negedge clk);
    chk("R8 clear priority", wel, 0);
  endtask

  task automatic t_burst_wrap();
    int w0 = we_cnt;
    pulse_set();
    tx_buf[0] = 8'h12; tx_buf[1] = 8'h1C;
    tx_buf[2] = 8'h11; tx_buf[3] = 8'h22; tx_buf[4] = 8'h33;
    spi_run(5, 0);
    exp_m[28] = 8'h11; exp_m[29] = 8'h22; exp_m[0] = 8'h33;
    chk("R2 three strobes", we_cnt - w0, 3);
    chk_mem("R2 R4 burst write with wrap");
    chk("R7 latch cleared after write", wel, 0);
  endtask

  task automatic t_read_wrap();
    pulse_set();
    tx_buf[0] = 8'h13; tx_buf[1] = 8'h1D; tx_buf[2] = 8'h00; tx_buf[3] = 8'h00;
    spi_run(4, 0);
    chk("R9 first read byte", rx_buf[2], exp_m[29]);
    chk("R4 read wraps to 00h", rx_buf[3], exp_m[0]);
    chk("R9 oe off during opcode/address", {oe_any[0], oe_any[1]}, 0);
    chk("R9 oe on during data", {oe_all[2], oe_all[3]}, 2'b11);
    chk("R9 oe off after deselect", spi_miso_oe, 0);
    chk("R7 read keeps latch", wel, 1);
    wel_clr = 1'b1; @(negedge clk); wel_clr = 1'b0; @(negedge clk);
  endtask

  task automatic t_partial();
    int w0 = we_cnt;
    pulse_set();
    tx_buf[0] = 8'h12; tx_buf[1] = 8'h05; tx_buf[2] = 8'h5A;
    spi_run(3, 4);
    exp_m[5] = 8'h5A;
    chk("R6 only full byte written", we_cnt - w0, 1);
    chk_mem("R6 partial byte dropped");
  endtask

  task automatic t_out_of_range();
    pulse_set();
    tx_buf[0] = 8'h12; tx_buf[1] = 8'h1F; tx_buf[2] = 8'h77;
    spi_run(3, 0);
    exp_m[0] = 8'h77;
    chk_mem("R5 write start replaced by 00h");
    tx_buf[0] = 8'h13; tx_buf[1] = 8'hFF; tx_buf[2] = 8'h00;
    spi_run(3, 0);
    chk("R5 read start replaced by 00h", rx_buf[2], 8'h77);
  endtask

  task automatic t_foreign();
    int w0 = we_cnt;
    int o0 = op_cnt;
    pulse_set();
    tx_buf[0] = 8'h06; tx_buf[1] = 8'h12; tx_buf[2] = 8'h05; tx_buf[3] = 8'h99;
    spi_run(4, 0);
    chk("R10 one op strobe", op_cnt - o0, 1);
    chk("R10 op code", last_op, 8'h06);
    chk("R10 no write", we_cnt - w0, 0);
    chk("R10 latch untouched", wel, 1);
    chk("R10 no output enable", {oe_any[1], oe_any[2], oe_any[3]}, 0);
    chk_mem("R10 registers unchanged");
  endtask

  task automatic t_reselect();
    tx_buf[0] = 8'h12;
    spi_run(0, 4);
    tx_buf[0] = 8'h12; tx_buf[1] = 8'h07; tx_buf[2] = 8'hC3;
    spi_run(3, 0);
    exp_m[7] = 8'hC3;
    chk_mem("R11 fresh opcode after partial one");
  endtask

  initial begin
    #(1_500_000ns);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 30; i++) exp_m[i] = 8'hA0 + 8'(i);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_locked_write();
    t_latch_ctrl();
    t_burst_wrap();
    t_read_wrap();
    t_partial();
    t_out_of_range();
    t_foreign();
    t_reselect();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule